// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block collects interrupt requests for one processor on two request levels: a normal level with sixteen inputs and a fast level with eight. Every input has a programmable priority, a trigger mode (level or edge), an edge polarity and a mask bit. A detected request is latched into a pending bit. An accepted request moves into an in-service bit, so interrupts can nest. Each level resolves its own winner and drives its own registered request line to the processor.

The processor reads a vector register to accept the winning request. A second address returns the same vector with no side effects. Writing the end-of-interrupt register finishes the most urgent request still in service. Software can raise normal-level requests directly, drop single pending bits, and set a lock threshold that hides the less urgent normal-level requests. The last two fast-level slots take their request from any normal-level pin, chosen by a selector register. All registers sit at word offsets on a simple single-cycle bus. A read returns data in the same cycle, and a write takes effect at the next clock edge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all pending and in-service bits are 0, all mask bits are 1, every normal priority reads 15 and every fast priority reads 7. Both request outputs are 0 and both level enables are off.
- R2: Trigger bit 1 selects edge mode and 0 selects level mode. In edge mode, polarity bit 0 catches a rising edge and 1 catches a falling edge, and a pulse one clock long is enough. In level mode, a high input sets the pending bit again on every clock while it stays high.
- R3: A detected request is latched into the pending register (normal offset 8) even when its mask bit (offset 3) is 1. The mask only keeps a pending input out of priority resolution.
- R4: Writing the software request register (offset 6) ORs its low 16 bits into the normal pending bits. These bits are then handled like hardware requests.
- R5: The winner is the eligible input with the numerically smallest priority. Priority 0 is the most urgent. On a tie the lowest index wins. The vector is the winner's index, zero-extended. With no winner the vector is 0xFFFFFFFF.
- R6: A read of the acknowledge address (offset 0) returns the vector, sets the winner's in-service bit (offset 9), clears its pending bit, and forces the output low on the following cycle. A read of the peek address (offset 1) returns the same value and changes nothing.
- R7: While any in-service bit is set, only inputs whose priority is strictly smaller than the smallest in-service priority are eligible.
- R8: A write of any value to the end-of-interrupt register (offset 2) clears the in-service bit with the smallest priority number, taking the lowest index on a tie.
- R9: The lock register is at offset 10. When its bit 8 is 1, normal inputs with priority greater than or equal to field [3:0] are not eligible.
- R10: Writing an index to the clear-pending register (offset 7) clears that single pending bit.
- R11: The fast level sits at base offset 32, with the same sub-offsets and priorities at 48 plus the index. Fast inputs 0 to 5 come from the fast pins. Fast inputs 6 and 7 come from the normal pin whose index is held at fast sub-offset 10 and 11 respectively.
- R12: Each request output is registered and equals its level's enable bit ANDed with "a winner exists", one cycle later. The enable register is at offset 11: bit 0 for the normal level, bit 1 for the fast level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 16 | Normal-level request pins |
| fiqIn | input | 6 | Fast-level request pins 0 to 5 |
| busSel | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Word offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| irqOut | output | 1 | Normal-level request to the processor |
| fiqOut | output | 1 | Fast-level request to the processor |

## Verification
The assertions check on every cycle that an accepted request is in service on the next cycle and that the output drops after an acknowledge. They also check that each end-of-interrupt removes exactly one in-service bit, that a winner is always pending and unmasked, that a winner never sits under the active lock threshold, and that a request output is only ever raised by an enabled level. The choice of winner needs the bench scenarios: the random reference model compares every vector against tie-breaking, nesting and mask changes. Directed scenarios cover edge polarity, level re-triggering, the lock threshold, the fast-slot selectors and the side-effect-free peek.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 32;

  // sub-offsets inside a level's 32-word window
  localparam logic [4:0] OFS_ACK   = 5'd0;
  localparam logic [4:0] OFS_PEEK  = 5'd1;
  localparam logic [4:0] OFS_EOI   = 5'd2;
  localparam logic [4:0] OFS_MASK  = 5'd3;
  localparam logic [4:0] OFS_TRIG  = 5'd4;
  localparam logic [4:0] OFS_POL   = 5'd5;
  localparam logic [4:0] OFS_SWREQ = 5'd6;
  localparam logic [4:0] OFS_CLRP  = 5'd7;
  localparam logic [4:0] OFS_PEND  = 5'd8;
  localparam logic [4:0] OFS_INSVC = 5'd9;
  localparam logic [4:0] OFS_AUX0  = 5'd10;
  localparam logic [4:0] OFS_AUX1  = 5'd11;

  localparam int unsigned LOCK_EN_BIT = 8;
  localparam logic [DATA_W-1:0] DEFAULT_VEC = 32'hFFFF_FFFF;

  typedef struct packed {
    logic       ack;
    logic       eoi;
    logic       wrMask;
    logic       wrTrig;
    logic       wrPol;
    logic       wrSw;
    logic       clrPend;
    logic       wrPrio;
    logic [3:0] idx;
  } lvlStrobe_t;
endpackage

// File: rtl/pic_level_dp.sv
module pic_level_dp
  import pic_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned PW = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rstN,
  input  lvlStrobe_t      strobe,
  input  logic [N-1:0]    wdata,
  input  logic [N-1:0]    rawReq,
  input  logic            lockEn,
  input  logic [PW-1:0]   lockLvl,
  output logic [N-1:0]    pendQ,
  output logic [N-1:0]    insvcQ,
  output logic [N-1:0]    maskQ,
  output logic [N-1:0]    trigQ,
  output logic [N-1:0]    polQ,
  output logic [N*PW-1:0] prioFlat,
  output logic            winValid,
  output logic [IW-1:0]   winIdx
);
  logic [PW-1:0] prioQ [N];
  logic [N-1:0]  prevQ;
  logic [N-1:0]  detect, swSet, ackClr, manClr, eoiClr;
  logic          anyIsv;
  logic [PW-1:0] ceilPrio, bestPrio;
  logic [IW-1:0] eoiIdx;
  logic          unusedIdx;

  assign unusedIdx = ^strobe.idx;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : gPrioOut
      assign prioFlat[g*PW +: PW] = prioQ[g];
    end
  endgenerate

  // request detection per input
  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (trigQ[i])
        detect[i] = polQ[i] ? (prevQ[i] & ~rawReq[i]) : (rawReq[i] & ~prevQ[i]);
      else
        detect[i] = rawReq[i];
    end
    swSet = strobe.wrSw ? wdata : '0;
  end

  // in-service ceiling and winner resolution
  always_comb begin
    anyIsv   = 1'b0;
    ceilPrio = '0;
    eoiIdx   = '0;
    for (int i = 0; i < N; i++) begin
      if (insvcQ[i] && (!anyIsv || prioQ[i] < ceilPrio)) begin
        anyIsv   = 1'b1;
        ceilPrio = prioQ[i];
        eoiIdx   = IW'(i);
      end
    end
    winValid = 1'b0;
    winIdx   = '0;
    bestPrio = '0;
    for (int i = 0; i < N; i++) begin
      if (pendQ[i] && !maskQ[i] && (!anyIsv || prioQ[i] < ceilPrio) &&
          !(lockEn && prioQ[i] >= lockLvl) &&
          (!winValid || prioQ[i] < bestPrio)) begin
        winValid = 1'b1;
        winIdx   = IW'(i);
        bestPrio = prioQ[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ackClr[i] = strobe.ack && winValid && (winIdx == IW'(i));
      manClr[i] = strobe.clrPend && (strobe.idx[IW-1:0] == IW'(i));
      eoiClr[i] = strobe.eoi && anyIsv && (eoiIdx == IW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ  <= '0;
      insvcQ <= '0;
      maskQ  <= '1;
      trigQ  <= '0;
      polQ   <= '0;
      prevQ  <= '0;
      for (int i = 0; i < N; i++) prioQ[i] <= '1;
    end else begin
      prevQ  <= rawReq;
      pendQ  <= (pendQ & ~(ackClr | manClr)) | detect | swSet;
      insvcQ <= (insvcQ & ~eoiClr) | ackClr;
      if (strobe.wrMask) maskQ <= wdata;
      if (strobe.wrTrig) trigQ <= wdata;
      if (strobe.wrPol)  polQ  <= wdata;
      if (strobe.wrPrio) prioQ[strobe.idx[IW-1:0]] <= wdata[PW-1:0];
    end
  end

  assert_ack_sets_insvc_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ack && winValid) |=> insvcQ[$past(winIdx)]);

  assert_eoi_clears_one_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eoi && !strobe.ack && (|insvcQ)) |=>
      ($countones(insvcQ) == $countones($past(insvcQ)) - 1));

  assert_winner_pending_unmasked_R3: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (pendQ[winIdx] && !maskQ[winIdx]));

  assert_winner_above_lock_R9: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && lockEn) |-> (prioQ[winIdx] < lockLvl));
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned NN  = 16,
  parameter int unsigned NF  = 8,
  parameter int unsigned NPW = 4,
  parameter int unsigned FPW = 3,
  localparam int unsigned NIW = $clog2(NN),
  localparam int unsigned FIW = $clog2(NF)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NN-1:0]      nPend,
  input  logic [NN-1:0]      nInsvc,
  input  logic [NN-1:0]      nMask,
  input  logic [NN-1:0]      nTrig,
  input  logic [NN-1:0]      nPol,
  input  logic [NN*NPW-1:0]  nPrio,
  input  logic               nWinValid,
  input  logic [NIW-1:0]     nWinIdx,
  input  logic [NF-1:0]      fPend,
  input  logic [NF-1:0]      fInsvc,
  input  logic [NF-1:0]      fMask,
  input  logic [NF-1:0]      fTrig,
  input  logic [NF-1:0]      fPol,
  input  logic [NF*FPW-1:0]  fPrio,
  input  logic               fWinValid,
  input  logic [FIW-1:0]     fWinIdx,
  output lvlStrobe_t         nStb,
  output lvlStrobe_t         fStb,
  output logic               lockEn,
  output logic [NPW-1:0]     lockLvl,
  output logic [NIW-1:0]     sel6,
  output logic [NIW-1:0]     sel7,
  output logic               irqOut,
  output logic               fiqOut
);
  logic       isFast, rdAcc, wrAcc, unusedWdata;
  logic [4:0] sub;
  logic [1:0] genQ;
  logic       irqQ, fiqQ;

  assign isFast      = busAddr[5];
  assign sub         = busAddr[4:0];
  assign rdAcc       = busSel && !busWrite;
  assign wrAcc       = busSel && busWrite;
  assign unusedWdata = ^busWdata;

  always_comb begin
    nStb         = '0;
    nStb.ack     = rdAcc && !isFast && sub == OFS_ACK && nWinValid;
    nStb.eoi     = wrAcc && !isFast && sub == OFS_EOI;
    nStb.wrMask  = wrAcc && !isFast && sub == OFS_MASK;
    nStb.wrTrig  = wrAcc && !isFast && sub == OFS_TRIG;
    nStb.wrPol   = wrAcc && !isFast && sub == OFS_POL;
    nStb.wrSw    = wrAcc && !isFast && sub == OFS_SWREQ;
    nStb.clrPend = wrAcc && !isFast && sub == OFS_CLRP;
    nStb.wrPrio  = wrAcc && !isFast && sub[4];
    nStb.idx     = sub[4] ? sub[3:0] : busWdata[3:0];

    fStb         = '0;
    fStb.ack     = rdAcc && isFast && sub == OFS_ACK && fWinValid;
    fStb.eoi     = wrAcc && isFast && sub == OFS_EOI;
    fStb.wrMask  = wrAcc && isFast && sub == OFS_MASK;
    fStb.wrTrig  = wrAcc && isFast && sub == OFS_TRIG;
    fStb.wrPol   = wrAcc && isFast && sub == OFS_POL;
    fStb.clrPend = wrAcc && isFast && sub == OFS_CLRP;
    fStb.wrPrio  = wrAcc && isFast && sub[4] && !sub[3];
    fStb.idx     = sub[4] ? sub[3:0] : busWdata[3:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockEn  <= 1'b0;
      lockLvl <= '0;
      genQ    <= '0;
      sel6    <= '0;
      sel7    <= '0;
      irqQ    <= 1'b0;
      fiqQ    <= 1'b0;
    end else begin
      if (wrAcc && !isFast && sub == OFS_AUX0) begin
        lockEn  <= busWdata[LOCK_EN_BIT];
        lockLvl <= busWdata[NPW-1:0];
      end
      if (wrAcc && !isFast && sub == OFS_AUX1) genQ <= busWdata[1:0];
      if (wrAcc && isFast && sub == OFS_AUX0)  sel6 <= busWdata[NIW-1:0];
      if (wrAcc && isFast && sub == OFS_AUX1)  sel7 <= busWdata[NIW-1:0];
      irqQ <= genQ[0] && nWinValid && !nStb.ack;
      fiqQ <= genQ[1] && fWinValid && !fStb.ack;
    end
  end

  assign irqOut = irqQ;
  assign fiqOut = fiqQ;

  always_comb begin
    busRdata = '0;
    if (rdAcc) begin
      if (!isFast) begin
        if (sub[4]) busRdata[NPW-1:0] = nPrio[sub[3:0]*NPW +: NPW];
        else begin
          case (sub)
            OFS_ACK, OFS_PEEK:
              busRdata = nWinValid ? {{(DATA_W-NIW){1'b0}}, nWinIdx} : DEFAULT_VEC;
            OFS_MASK:  busRdata[NN-1:0] = nMask;
            OFS_TRIG:  busRdata[NN-1:0] = nTrig;
            OFS_POL:   busRdata[NN-1:0] = nPol;
            OFS_PEND:  busRdata[NN-1:0] = nPend;
            OFS_INSVC: busRdata[NN-1:0] = nInsvc;
            OFS_AUX0:  begin
              busRdata[LOCK_EN_BIT] = lockEn;
              busRdata[NPW-1:0]     = lockLvl;
            end
            OFS_AUX1:  busRdata[1:0] = genQ;
            default:   busRdata = '0;
          endcase
        end
      end else begin
        if (sub[4]) begin
          if (!sub[3]) busRdata[FPW-1:0] = fPrio[sub[2:0]*FPW +: FPW];
        end else begin
          case (sub)
            OFS_ACK, OFS_PEEK:
              busRdata = fWinValid ? {{(DATA_W-FIW){1'b0}}, fWinIdx} : DEFAULT_VEC;
            OFS_MASK:  busRdata[NF-1:0] = fMask;
            OFS_TRIG:  busRdata[NF-1:0] = fTrig;
            OFS_POL:   busRdata[NF-1:0] = fPol;
            OFS_PEND:  busRdata[NF-1:0] = fPend;
            OFS_INSVC: busRdata[NF-1:0] = fInsvc;
            OFS_AUX0:  busRdata[NIW-1:0] = sel6;
            OFS_AUX1:  busRdata[NIW-1:0] = sel7;
            default:   busRdata = '0;
          endcase
        end
      end
    end
  end

  assert_irq_needs_enable_R12: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> $past(genQ[0]));

  assert_fiq_needs_enable_R12: assert property (@(posedge clk) disable iff (!rstN)
    fiqQ |-> $past(genQ[1]));

  assert_ack_drops_irq_R6: assert property (@(posedge clk) disable iff (!rstN)
    nStb.ack |=> !irqQ);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned N_NORM   = 16,
  parameter int unsigned N_FAST   = 8,
  parameter int unsigned N_DIRECT = 6,
  localparam int unsigned NPW = $clog2(N_NORM),
  localparam int unsigned FPW = $clog2(N_FAST),
  localparam int unsigned NIW = $clog2(N_NORM),
  localparam int unsigned FIW = $clog2(N_FAST)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_NORM-1:0]  irqIn,
  input  logic [N_DIRECT-1:0] fiqIn,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut,
  output logic               fiqOut
);
  lvlStrobe_t nStb, fStb;
  logic [N_NORM-1:0] nPend, nInsvc, nMask, nTrig, nPol;
  logic [N_FAST-1:0] fPend, fInsvc, fMask, fTrig, fPol, fRaw;
  logic [N_NORM*NPW-1:0] nPrio;
  logic [N_FAST*FPW-1:0] fPrio;
  logic nWinValid, fWinValid, lockEn;
  logic [NIW-1:0] nWinIdx, sel6, sel7;
  logic [FIW-1:0] fWinIdx;
  logic [NPW-1:0] lockLvl;

  assign fRaw = {irqIn[sel7], irqIn[sel6], fiqIn};

  pic_ctrl #(.NN(N_NORM), .NF(N_FAST), .NPW(NPW), .FPW(FPW)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .nPend(nPend), .nInsvc(nInsvc), .nMask(nMask), .nTrig(nTrig), .nPol(nPol),
    .nPrio(nPrio), .nWinValid(nWinValid), .nWinIdx(nWinIdx),
    .fPend(fPend), .fInsvc(fInsvc), .fMask(fMask), .fTrig(fTrig), .fPol(fPol),
    .fPrio(fPrio), .fWinValid(fWinValid), .fWinIdx(fWinIdx),
    .nStb(nStb), .fStb(fStb), .lockEn(lockEn), .lockLvl(lockLvl),
    .sel6(sel6), .sel7(sel7), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  pic_level_dp #(.N(N_NORM), .PW(NPW)) uNorm (
    .clk(clk), .rstN(rstN), .strobe(nStb), .wdata(busWdata[N_NORM-1:0]),
    .rawReq(irqIn), .lockEn(lockEn), .lockLvl(lockLvl),
    .pendQ(nPend), .insvcQ(nInsvc), .maskQ(nMask), .trigQ(nTrig), .polQ(nPol),
    .prioFlat(nPrio), .winValid(nWinValid), .winIdx(nWinIdx)
  );

  pic_level_dp #(.N(N_FAST), .PW(FPW)) uFast (
    .clk(clk), .rstN(rstN), .strobe(fStb), .wdata(busWdata[N_FAST-1:0]),
    .rawReq(fRaw), .lockEn(1'b0), .lockLvl('0),
    .pendQ(fPend), .insvcQ(fInsvc), .maskQ(fMask), .trigQ(fTrig), .polQ(fPol),
    .prioFlat(fPrio), .winValid(fWinValid), .winIdx(fWinIdx)
  );
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam logic [5:0] A_ACK = 0, A_PEEK = 1, A_EOI = 2, A_MASK = 3, A_TRIG = 4,
    A_POL = 5, A_SW = 6, A_CLRP = 7, A_PEND = 8, A_ISV = 9, A_LOCK = 10, A_GEN = 11,
    A_PRIO = 16, F_ACK = 32, F_PEEK = 33, F_EOI = 34, F_MASK = 35, F_TRIG = 36,
    F_PEND = 40, F_SEL6 = 42, F_PRIO = 48;

  logic clk = 1'b0, rstN = 1'b0;
  logic [15:0] irqIn = '0;
  logic [5:0] fiqIn = '0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [5:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic irqOut, fiqOut;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [15:0] pendM, isvM, maskM;
  int prioM [16];

  prio_irq_ctrl uut (.clk(clk), .rstN(rstN), .irqIn(irqIn), .fiqIn(fiqIn),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut), .fiqOut(fiqOut));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int modelWin();
    int w = -1;
    int ceilP = 16;
    for (int i = 0; i < 16; i++) if (isvM[i] && prioM[i] < ceilP) ceilP = prioM[i];
    for (int i = 0; i < 16; i++)
      if (pendM[i] && !maskM[i] && prioM[i] < ceilP && (w < 0 || prioM[i] < prioM[w])) w = i;
    return w;
  endfunction

  function automatic logic [31:0] vecOf(input int w);
    return (w < 0) ? 32'hFFFF_FFFF : 32'(w);
  endfunction

  task automatic modelEoi();
    int e = -1;
    for (int i = 0; i < 16; i++) if (isvM[i] && (e < 0 || prioM[i] < prioM[e])) e = i;
    if (e >= 0) isvM[e] = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    idle(4);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    rdChk("R1 pend", A_PEND, 0);
    rdChk("R1 insvc", A_ISV, 0);
    rdChk("R1 mask", A_MASK, 32'hFFFF);
    rdChk("R1 prio", A_PRIO + 5, 15);
    rdChk("R1 fast prio", F_PRIO + 3, 7);
    rdChk("R1 fast mask", F_MASK, 32'hFF);
    rdChk("R5 default vec", A_PEEK, 32'hFFFF_FFFF);
    chk("R1 irqOut", {31'b0, irqOut}, 0);
    chk("R1 fiqOut", {31'b0, fiqOut}, 0);

    wr(A_GEN, 3);
    // R3 / R4: masked software requests still pend
    wr(A_SW, 32'h0208);
    rdChk("R4 sw pend", A_PEND, 32'h0208);
    rdChk("R3 masked no winner", A_PEEK, 32'hFFFF_FFFF);
    chk("R3 irq stays low", {31'b0, irqOut}, 0);
    // R10 clear single pending bit
    wr(A_CLRP, 3);
    rdChk("R10 clear bit3", A_PEND, 32'h0200);
    wr(A_CLRP, 9);
    rdChk("R10 clear bit9", A_PEND, 0);

    // R2 edge and level detection
    wr(A_TRIG, 32'h0014);
    wr(A_POL, 32'h0010);
    @(negedge clk); irqIn[2] = 1'b1;
    @(negedge clk); irqIn[2] = 1'b0;
    rdChk("R2 rising pulse", A_PEND, 32'h0004);
    @(negedge clk); irqIn[4] = 1'b1;
    idle(2);
    rdChk("R2 falling ignores rise", A_PEND, 32'h0004);
    @(negedge clk); irqIn[4] = 1'b0;
    rdChk("R2 falling edge", A_PEND, 32'h0014);
    @(negedge clk); irqIn[6] = 1'b1;
    idle(1);
    wr(A_CLRP, 6);
    rdChk("R2 level re-pends", A_PEND, 32'h0054);
    @(negedge clk); irqIn[6] = 1'b0;
    wr(A_CLRP, 6); wr(A_CLRP, 4); wr(A_CLRP, 2);
    rdChk("R10 all cleared", A_PEND, 0);

    // random phase against the reference model
    pendM = '0; isvM = '0; maskM = 16'hFFFF;
    for (int i = 0; i < 16; i++) prioM[i] = 15;
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 7);
      int w = modelWin();
      case (op)
        0, 1: begin
          logic [15:0] s = 16'($urandom & $urandom);
          wr(A_SW, {16'b0, s}); pendM |= s;
        end
        2: begin
          logic [15:0] m = 16'($urandom);
          wr(A_MASK, {16'b0, m}); maskM = m;
        end
        3: begin
          int ix = $urandom_range(0, 15);
          int v = $urandom_range(0, 15);
          wr(A_PRIO + 6'(ix), 32'(v)); prioM[ix] = v;
        end
        4: rdChk("R5 random peek", A_PEEK, vecOf(w));
        5: begin
          rdChk("R6 random ack", A_ACK, vecOf(w));
          if (w >= 0) begin isvM[w] = 1'b1; pendM[w] = 1'b0; end
        end
        6: begin wr(A_EOI, 32'h5A); modelEoi(); end
        default: begin
          int ix = $urandom_range(0, 15);
          wr(A_CLRP, 32'(ix)); pendM[ix] = 1'b0;
        end
      endcase
      idle(1);
      chk("R12 random irq", {31'b0, irqOut}, {31'b0, modelWin() >= 0});
    end
    rdChk("R7 model pend", A_PEND, {16'b0, pendM});
    rdChk("R8 model insvc", A_ISV, {16'b0, isvM});
    for (int i = 0; i < 16; i++) wr(A_EOI, 0);
    for (int i = 0; i < 16; i++) wr(A_CLRP, i);
    rdChk("R8 drained insvc", A_ISV, 0);

    // nesting
    wr(A_MASK, 0);
    wr(A_PRIO + 1, 8); wr(A_PRIO + 2, 3); wr(A_PRIO + 3, 12);
    wr(A_SW, 32'h2);
    rdChk("R6 ack vec", A_ACK, 1);
    idle(1);
    chk("R6 irq dropped", {31'b0, irqOut}, 0);
    rdChk("R6 pend cleared", A_PEND, 0);
    rdChk("R6 insvc set", A_ISV, 32'h2);
    wr(A_SW, 32'h8);
    rdChk("R7 lower blocked", A_PEEK, 32'hFFFF_FFFF);
    idle(1);
    chk("R7 irq low while blocked", {31'b0, irqOut}, 0);
    wr(A_SW, 32'h4);
    rdChk("R7 higher nests", A_PEEK, 2);
    idle(1);
    chk("R7 irq for nested", {31'b0, irqOut}, 1);
    rdChk("R6 ack nested", A_ACK, 2);
    rdChk("R6 insvc two", A_ISV, 32'h6);
    wr(A_EOI, 0);
    rdChk("R8 top cleared first", A_ISV, 32'h2);
    rdChk("R7 still blocked", A_PEEK, 32'hFFFF_FFFF);
    wr(A_EOI, 0);
    rdChk("R8 all cleared", A_ISV, 0);
    rdChk("R6 peek once", A_PEEK, 3);
    rdChk("R6 peek twice", A_PEEK, 3);
    rdChk("R6 peek no side effect", A_PEND, 32'h8);

    // lock threshold
    wr(A_LOCK, 32'h10C);
    rdChk("R9 locked at equal", A_PEEK, 32'hFFFF_FFFF);
    wr(A_LOCK, 32'h10D);
    rdChk("R9 above lock passes", A_PEEK, 3);
    wr(A_LOCK, 32'h10C);
    rdChk("R5 ack with nothing", A_ACK, 32'hFFFF_FFFF);
    rdChk("R6 empty ack no insvc", A_ISV, 0);
    wr(A_LOCK, 0);
    rdChk("R6 ack after unlock", A_ACK, 3);
    wr(A_EOI, 0);

    // tie-break
    wr(A_PRIO + 5, 4); wr(A_PRIO + 7, 4);
    wr(A_SW, 32'hA0);
    rdChk("R5 tie lowest index", A_ACK, 5);
    wr(A_EOI, 0);
    rdChk("R5 tie second", A_ACK, 7);
    wr(A_EOI, 0);

    // global enable
    wr(A_GEN, 2);
    wr(A_SW, 32'h2);
    idle(2);
    chk("R12 disabled level", {31'b0, irqOut}, 0);
    wr(A_GEN, 3);
    idle(1);
    chk("R12 enabled level", {31'b0, irqOut}, 1);
    rdChk("R6 ack gen", A_ACK, 1);
    wr(A_EOI, 0);

    // fast level with selected normal pin
    wr(F_SEL6, 10);
    wr(F_MASK, 0);
    wr(F_TRIG, 32'h41);
    wr(F_PRIO + 6, 2);
    @(negedge clk); irqIn[10] = 1'b1;
    @(negedge clk); irqIn[10] = 1'b0;
    rdChk("R11 slot6 from pin10", F_PEND, 32'h40);
    rdChk("R11 fast peek", F_PEEK, 6);
    idle(1);
    chk("R12 fiq raised", {31'b0, fiqOut}, 1);
    @(negedge clk); fiqIn[0] = 1'b1;
    @(negedge clk); fiqIn[0] = 1'b0;
    rdChk("R11 direct fast pin", F_PEND, 32'h41);
    rdChk("R5 fast priority", F_PEEK, 6);
    rdChk("R6 fast ack", F_ACK, 6);
    idle(1);
    chk("R7 fast lower blocked", {31'b0, fiqOut}, 0);
    wr(F_EOI, 0);
    rdChk("R8 fast after eoi", F_PEEK, 0);
    idle(1);
    chk("R12 fiq again", {31'b0, fiqOut}, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule